// File: doc/BRIEF.md
# Constant Coefficient Shift-Add Multiplier

This block multiplies a `WIDTH`-bit data word by a coefficient that is fixed when the design is elaborated. No general multiplier is built. The coefficient's bit pattern is scanned at elaboration, and every unbroken stretch of 1s becomes one shifted copy of the input added and one shifted copy subtracted. A stretch that is a single bit becomes one shifted copy. The hardware therefore scales with the number of such stretches, and the worst case is an alternating 0101... pattern. The product is always `2*WIDTH` bits wide, so no coefficient and data combination can overflow.

The block serves fixed-coefficient datapaths such as the taps of a transposed-form FIR filter. In each tap the product feeds straight into an adder chain. Data can be unsigned or two's complement. In two's-complement mode the coefficient parameter holds a magnitude, and a separate sign parameter makes the effective coefficient negative. The path is purely combinational and has no clock or reset.

Top module: `cmul_shift_add`

## Requirements
- R1: `prod_o` is `2*WIDTH` bits wide and always equals data times the effective coefficient modulo 2^(2*WIDTH). It follows `data_i` combinationally, and a zero input gives a zero output.
- R2: With `IS_SIGNED`=0, `data_i` and `COEF` are unsigned integers and `prod_o` is their exact unsigned product. For example, WIDTH=8, COEF=8'h55 and data 8'hFF give 16'h54AB.
- R3: With `IS_SIGNED`=1, `data_i` is two's complement and the effective coefficient is `COEF` when `NEGATE`=0, or minus `COEF` when `NEGATE`=1. `prod_o` is the exact two's-complement product.
- R4: With `IS_SIGNED`=0, `NEGATE` has no effect. For example, WIDTH=5, COEF=5'h1B, NEGATE=1 and data 5'h1F give 10'h345.
- R5: A `COEF` of zero drives `prod_o` to all zeros for every data value.
- R6: A power-of-two `COEF` gives the input shifted left by log2(`COEF`), extended by the input's sign in signed mode. For example, WIDTH=6, COEF=8 and data 6'h20 give 12'hF00.
- R7: The alternating worst-case coefficient 8'h55 gives exact products in both modes. In signed mode, data 8'h80 gives 16'hD580.
- R8: With WIDTH=4, signed mode, COEF=4, NEGATE=1 and data 4'b1000, the output is 8'h20, and bit 7 equals bit 6.
- R9: The extreme magnitude case is exact. With WIDTH=8, signed mode, COEF=8'hFF, NEGATE=1 and data 8'h80, the output is 16'h7F80.
- R10: In signed mode with nonzero data and nonzero `COEF`, the top output bit equals the data's top bit XOR `NEGATE`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | WIDTH | Data word, unsigned or two's complement |
| prod_o | output | 2*WIDTH | Data times the effective coefficient |

## Verification
The hardest behaviour to reach from the ports is the one set by the parameters: run recoding, the single-bit-run variant, the zero-coefficient path and the negation stage. A port toggle cannot select any of these, because each depends on the coefficient chosen at elaboration. The bench therefore builds seven copies with different coefficients, modes and signs, and drives them all from one shared 8-bit sweep sliced to each width. This makes every copy see its full input space, including the most negative word against an all-ones negated magnitude, where the product sits closest to the output's range limit.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

  // number of unbroken stretches of 1s in the low w bits of c
  function automatic int run_count(logic [63:0] c, int w);
    int  n;
    bit  prev;
    n    = 0;
    prev = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (i < w) begin
        if (c[i] && !prev) n++;
        prev = c[i];
      end
    end
    return n;
  endfunction

  // lowest bit index of stretch k
  function automatic int run_lo(logic [63:0] c, int w, int k);
    int  n;
    bit  prev;
    n    = 0;
    prev = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (i < w) begin
        if (c[i] && !prev) begin
          if (n == k) return i;
          n++;
        end
        prev = c[i];
      end
    end
    return 0;
  endfunction

  // bit index just above stretch k
  function automatic int run_hi(logic [63:0] c, int w, int k);
    int  n;
    int  cur;
    bit  prev;
    n    = 0;
    cur  = -1;
    prev = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (i < w) begin
        if (c[i] && !prev) begin
          cur = n;
          n++;
        end
        if (!c[i] && prev && cur == k) return i;
        prev = c[i];
      end
    end
    return w;
  endfunction

endpackage

// File: rtl/cmul_extend.sv
module cmul_extend #(
  parameter int WIDTH     = 8,
  parameter bit IS_SIGNED = 1'b0,
  localparam int PW       = 2 * WIDTH
) (
  input  logic [WIDTH-1:0] data_i,
  output logic [PW-1:0]    ext_o
);
  if (IS_SIGNED) begin : g_sext
    assign ext_o = {{WIDTH{data_i[WIDTH-1]}}, data_i};
  end else begin : g_zext
    assign ext_o = {{WIDTH{1'b0}}, data_i};
  end
endmodule

// File: rtl/cmul_run_term.sv
module cmul_run_term #(
  parameter int PW = 16,
  parameter int LO = 0,
  parameter int HI = 1
) (
  input  logic [PW-1:0] x_i,
  output logic [PW-1:0] term_o
);
  if (HI == LO + 1) begin : g_single
    assign term_o = x_i << LO;
  end else begin : g_span
    assign term_o = (x_i << HI) - (x_i << LO);
  end
endmodule

// File: rtl/cmul_sum.sv
module cmul_sum #(
  parameter int PW    = 16,
  parameter int NTERM = 1
) (
  input  logic [PW-1:0] term_i [NTERM],
  output logic [PW-1:0] sum_o
);
  always_comb begin
    sum_o = '0;
    for (int k = 0; k < NTERM; k++) sum_o = sum_o + term_i[k];
  end
endmodule

// File: rtl/cmul_shift_add.sv
module cmul_shift_add #(
  parameter int               WIDTH     = 8,
  parameter bit               IS_SIGNED = 1'b1,
  parameter bit               NEGATE    = 1'b0,
  parameter logic [WIDTH-1:0] COEF      = WIDTH'(8'h55)
) (
  input  logic [WIDTH-1:0]   data_i,
  output logic [2*WIDTH-1:0] prod_o
);
  localparam int          PW     = 2 * WIDTH;
  localparam logic [63:0] COEF64 = 64'(COEF);
  localparam int          NRUN   = cmul_pkg::run_count(COEF64, WIDTH);
  localparam int          NSLOT  = (NRUN == 0) ? 1 : NRUN;

  logic [PW-1:0] xext;
  logic [PW-1:0] term [NSLOT];
  logic [PW-1:0] mag_sum;

  cmul_extend #(.WIDTH(WIDTH), .IS_SIGNED(IS_SIGNED)) u_ext (
    .data_i (data_i),
    .ext_o  (xext)
  );

  if (NRUN == 0) begin : g_none
    assign term[0] = '0;
  end else begin : g_runs
    for (genvar g = 0; g < NRUN; g++) begin : g_run
      cmul_run_term #(
        .PW (PW),
        .LO (cmul_pkg::run_lo(COEF64, WIDTH, g)),
        .HI (cmul_pkg::run_hi(COEF64, WIDTH, g))
      ) u_term (
        .x_i    (xext),
        .term_o (term[g])
      );
    end
  end

  cmul_sum #(.PW(PW), .NTERM(NSLOT)) u_sum (
    .term_i (term),
    .sum_o  (mag_sum)
  );

  if (IS_SIGNED && NEGATE) begin : g_neg
    assign prod_o = -mag_sum;
  end else begin : g_pos
    assign prod_o = mag_sum;
  end
endmodule

// File: rtl/cmul_shift_add_chk.sv
module cmul_shift_add_chk #(
  parameter int               WIDTH     = 8,
  parameter bit               IS_SIGNED = 1'b1,
  parameter bit               NEGATE    = 1'b0,
  parameter logic [WIDTH-1:0] COEF      = '0
) (
  input logic [WIDTH-1:0]   data_i,
  input logic [2*WIDTH-1:0] prod_o
);
  localparam int PW = 2 * WIDTH;
  localparam int SH = $clog2(COEF);

  logic [PW-1:0] dx;
  logic [PW-1:0] cx;
  logic [PW-1:0] ref_v;
  logic [PW-1:0] shf_v;

  always_comb begin
    dx    = IS_SIGNED ? {{WIDTH{data_i[WIDTH-1]}}, data_i} : {{WIDTH{1'b0}}, data_i};
    cx    = {{WIDTH{1'b0}}, COEF};
    if (IS_SIGNED && NEGATE) cx = -cx;
    ref_v = PW'(dx * cx);
    shf_v = dx << SH;
    if (IS_SIGNED && NEGATE) shf_v = -shf_v;
  end

  always_comb begin
    // R1, R2, R3: product matches behavioural multiply
    assert_product_R1 : assert (prod_o == ref_v);
    if (data_i == '0) begin
      assert_zero_data_R1 : assert (prod_o == '0);
    end
    if (COEF == '0) begin
      assert_zero_coef_R5 : assert (prod_o == '0);
    end
    if ($countones(COEF) == 1) begin
      assert_pow2_shift_R6 : assert (prod_o == shf_v);
    end
    if (IS_SIGNED && data_i != '0 && COEF != '0) begin
      assert_sign_R10 : assert (prod_o[PW-1] == (data_i[WIDTH-1] ^ NEGATE));
    end
  end
endmodule

bind cmul_shift_add cmul_shift_add_chk #(
  .WIDTH(WIDTH), .IS_SIGNED(IS_SIGNED), .NEGATE(NEGATE), .COEF(COEF)
) u_chk (
  .data_i (data_i),
  .prod_o (prod_o)
);

// File: tb/sim_cmul_shift_add.sv
`timescale 1ns/1ps
module sim_cmul_shift_add;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] stim = '0;
  int         n_chk = 0;
  int         n_bad = 0;
  int         cyc = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  logic [7:0]  p0;
  logic [15:0] p1, p2, p6;
  logic [11:0] p3, p4;
  logic [9:0]  p5;

  cmul_shift_add #(.WIDTH(4), .IS_SIGNED(1), .NEGATE(1), .COEF(4'h4)) u0 (.data_i(stim[3:0]), .prod_o(p0));
  cmul_shift_add #(.WIDTH(8), .IS_SIGNED(0), .NEGATE(0), .COEF(8'h55)) u1 (.data_i(stim), .prod_o(p1));
  cmul_shift_add #(.WIDTH(8), .IS_SIGNED(1), .NEGATE(0), .COEF(8'h55)) u2 (.data_i(stim), .prod_o(p2));
  cmul_shift_add #(.WIDTH(6), .IS_SIGNED(1), .NEGATE(1), .COEF(6'h00)) u3 (.data_i(stim[5:0]), .prod_o(p3));
  cmul_shift_add #(.WIDTH(6), .IS_SIGNED(1), .NEGATE(0), .COEF(6'h08)) u4 (.data_i(stim[5:0]), .prod_o(p4));
  cmul_shift_add #(.WIDTH(5), .IS_SIGNED(0), .NEGATE(1), .COEF(5'h1B)) u5 (.data_i(stim[4:0]), .prod_o(p5));
  cmul_shift_add #(.WIDTH(8), .IS_SIGNED(1), .NEGATE(1), .COEF(8'hFF)) u6 (.data_i(stim), .prod_o(p6));

  // u0 directed vectors: {data[3:0], expected[7:0]}
  localparam logic [11:0] TBL [5] = '{12'h8_20, 12'h7_E4, 12'h0_00, 12'hF_04, 12'h1_FC};

  function automatic longint expect_v(longint raw, int w, bit sg, longint coef, bit neg);
    longint d, c;
    d = raw & ((longint'(1) << w) - 1);
    if (sg && d[w-1]) d = d - (longint'(1) << w);
    c = (sg && neg) ? -coef : coef;
    return (d * c) & ((longint'(1) << (2 * w)) - 1);
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s stim=%h actual=%h expected=%h", req, stim, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle state, zero input gives zero everywhere
    chk("R1", p0, 0); chk("R1", p1, 0); chk("R1", p2, 0); chk("R1", p6, 0);

    // R8 / R3: table walk on u0
    foreach (TBL[i]) begin
      @(posedge clk); stim = {4'h0, TBL[i][11:8]};
      @(negedge clk);
      chk("R8", p0, TBL[i][7:0]);
      if (TBL[i][11:8] == 4'h8) chk("R8", p0[7], p0[6]);
    end

    // exhaustive sweep, all copies
    for (int v = 0; v < 256; v++) begin
      @(posedge clk); stim = 8'(v);
      @(negedge clk);
      chk("R3", p0, expect_v(v, 4, 1, 4, 1));
      chk("R2", p1, expect_v(v, 8, 0, 85, 0));
      chk("R7", p2, expect_v(v, 8, 1, 85, 0));
      chk("R5", p3, 0);
      chk("R6", p4, expect_v(v, 6, 1, 8, 0));
      chk("R4", p5, expect_v(v, 5, 0, 27, 0));
      chk("R9", p6, expect_v(v, 8, 1, 255, 1));
      if (v != 0) chk("R10", p2[15], stim[7]);
    end

    // directed corners
    @(posedge clk); stim = 8'h80; @(negedge clk);
    chk("R9", p6, 16'h7F80);
    chk("R7", p2, 16'hD580);
    @(posedge clk); stim = 8'hFF; @(negedge clk);
    chk("R2", p1, 16'h54AB);
    chk("R4", p5, 10'h345);
    chk("R10", p6[15], 1'b0);
    @(posedge clk); stim = 8'h20; @(negedge clk);
    chk("R6", p4, 12'hF00);
    chk("R5", p3, 12'h000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule